// File: doc/BRIEF.md
# Sticky Start-Trigger Capture with Demonstration Controller

This block makes sure a downstream controller never misses a start request. The request may come as a single-cycle high pulse, a rising edge or a falling edge on an input that may be asynchronous to the clock. The raw input first passes through a flop synchronizer and then shifts into a four-sample history on every clock. This sampling does not depend on what the controller is doing.

A decoder looks at the history and flags the selected event. For edges, an optional filter accepts a transition only when two stable samples come before it and two stable samples come after it. Each detected event sets a sticky pending flag. The flag holds until the controller accepts it. An event that arrives while the controller is busy therefore waits instead of being lost.

The demonstration controller has three states:
- `CS_IDLE`: waits for work.
- `CS_RUN`: lasts a fixed, parameterised number of cycles.
- `CS_DONE`: lasts one cycle.

The transitions are:
- IDLE→RUN: on an accepted start.
- RUN→RUN: while the run counter has not reached its limit.
- RUN→DONE: at the limit.
- DONE→IDLE: always.

Top module: `trig_capture_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the synchronizer, the history, the pending flag and the controller. After it, `start_pending`, `start_fire` and `ctl_busy` are all 0.
- R2: A raw sample taken at edge k enters the newest history slot at edge k+SYNC_STAGES. An unfiltered rising edge whose first high sample is taken at edge k sets `start_pending` after edge k+SYNC_STAGES+1.
- R3: With `trig_mode`=2'b00 (pulse), an event is exactly one high sample with a low sample on each side. A high lasting two or more samples produces no event. `filt_en` has no effect in this mode.
- R4: With `filt_en`=0, `trig_mode`=2'b01 flags a low-then-high pair of consecutive samples, and `trig_mode`=2'b10 flags a high-then-low pair.
- R5: With `filt_en`=1, a rising event needs the history (oldest to newest) to read 0,0,1,1 and a falling event needs 1,1,0,0. A single-sample glitch produces no event.
- R6: An input held steadily high or steadily low never produces an event. `trig_mode`=2'b11 never produces an event.
- R7: Once set, `start_pending` stays set until a start is accepted.
- R8: `start_fire` is high only when the controller is idle, `start_pending` is 1 and `ack` is 1. It lasts one cycle, and `start_pending` falls at the same edge unless R9 applies.
- R9: If an event is detected in the same cycle as `start_fire`, `start_pending` stays set.
- R10: After `start_fire` the controller spends RUN_LEN cycles in RUN and one cycle in DONE, then returns to IDLE. `ctl_busy` is 1 in RUN and DONE.
- R11: Events that occur while the controller is busy are served by a `start_fire` once it is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous reset, active high |
| start_raw | input | 1 | Raw, possibly asynchronous start input |
| trig_mode | input | 2 | 00 pulse, 01 rising, 10 falling, 11 disabled |
| filt_en | input | 1 | Enables the two-before/two-after edge filter |
| ack | input | 1 | Controller permission to accept a pending start |
| start_pending | output | 1 | Sticky request flag |
| start_fire | output | 1 | One-cycle strobe when a start is accepted |
| ctl_busy | output | 1 | Controller is in RUN or DONE |

## Verification
The bench builds the block with RUN_LEN=4 and SYNC_STAGES=2. The short busy window lets pulses land inside RUN and DONE and then be served. A sweep of acknowledge timing places a new detection in exactly the cycle of a fire. A behavioural model with a sample delay queue predicts all three outputs on every clock. The stimulus covers every mode, with and without the filter, including glitches and random segments.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        TM_PULSE = 2'b00,
        TM_RISE  = 2'b01,
        TM_FALL  = 2'b10,
        TM_NONE  = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'b00,
        CS_RUN  = 2'b01,
        CS_DONE = 2'b10
    } ctl_state_e;

    localparam int HIST_LEN = 4;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp,
    input  logic [1:0] mode,
    input  logic       filt_en,
    output logic       evt
);
    logic [HIST_LEN-1:0] hist;   // hist[0] newest, hist[3] oldest
    trig_mode_e          mode_e;

    assign mode_e = trig_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[HIST_LEN-2:0], smp};
    end

    always_comb begin
        evt = 1'b0;
        unique case (mode_e)
            TM_PULSE: evt = !hist[2] && hist[1] && !hist[0];
            TM_RISE:  evt = filt_en ? (hist == 4'b0011) : (!hist[1] && hist[0]);
            TM_FALL:  evt = filt_en ? (hist == 4'b1100) : (hist[1] && !hist[0]);
            TM_NONE:  evt = 1'b0;
            default:  evt = 1'b0;
        endcase
    end

    // steady input never yields an event (R6)
    assert_steady_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(smp) == smp && hist == {HIST_LEN{smp}}) |-> !evt);
endmodule

// File: rtl/trig_pending.sv
module trig_pending (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic fire,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= evt | (pending & ~fire);
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (pending && !fire) |=> pending);

    assert_evt_kept_R9: assert property (@(posedge clk) disable iff (rst)
        evt |=> pending);
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
    import trig_pkg::*;
#(
    parameter int RUN_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic ack,
    output logic fire,
    output logic busy
);
    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

    ctl_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == CS_RUN) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE: if (pending && ack)   state_nx = CS_RUN;
            CS_RUN:  if (cnt == CNT_LAST)  state_nx = CS_DONE;
            CS_DONE: state_nx = CS_IDLE;
            default: state_nx = CS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        busy = 1'b1;
        unique case (state)
            CS_IDLE: begin
                busy = 1'b0;
                fire = pending && ack;
            end
            CS_RUN:  busy = 1'b1;
            CS_DONE: busy = 1'b1;
            default: busy = 1'b1;
        endcase
    end

    assert_fire_starts_run_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> (state == CS_RUN) && !fire);

    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == CS_DONE) |=> (state == CS_IDLE));

    assert_run_from_fire_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fire));
endmodule

// File: rtl/trig_capture_top.sv
module trig_capture_top #(
    parameter int SYNC_STAGES = 2,
    parameter int RUN_LEN     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_raw,
    input  logic [1:0] trig_mode,
    input  logic       filt_en,
    input  logic       ack,
    output logic       start_pending,
    output logic       start_fire,
    output logic       ctl_busy
);
    logic smp, evt;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(start_raw), .dout(smp)
    );

    trig_detect u_det (
        .clk(clk), .rst(rst), .smp(smp), .mode(trig_mode),
        .filt_en(filt_en), .evt(evt)
    );

    trig_pending u_pend (
        .clk(clk), .rst(rst), .evt(evt), .fire(start_fire),
        .pending(start_pending)
    );

    trig_ctrl #(.RUN_LEN(RUN_LEN)) u_ctl (
        .clk(clk), .rst(rst), .pending(start_pending), .ack(ack),
        .fire(start_fire), .busy(ctl_busy)
    );

    assert_fire_needs_pending_R8: assert property (@(posedge clk) disable iff (rst)
        start_fire |-> start_pending && ack && !ctl_busy);
endmodule

// File: tb/tb_trig_capture_top.sv
module tb_trig_capture_top;
    localparam int S   = 2;
    localparam int RL  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_raw = 1'b0;
    logic [1:0] trig_mode = 2'b01;
    logic       filt_en = 1'b0;
    logic       ack = 1'b0;
    logic       start_pending, start_fire, ctl_busy;

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R1";
    bit    cmp_on   = 0;
    bit    finished = 0;

    // behavioural reference
    int q[$];
    int m_st = 0, m_cnt = 0, m_pend = 0;

    always #10 clk = ~clk;

    trig_capture_top #(.SYNC_STAGES(S), .RUN_LEN(RL)) dut (
        .clk(clk), .rst(rst), .start_raw(start_raw), .trig_mode(trig_mode),
        .filt_en(filt_en), .ack(ack), .start_pending(start_pending),
        .start_fire(start_fire), .ctl_busy(ctl_busy)
    );

    function automatic int m_evt();
        int n0 = q[S], n1 = q[S+1], n2 = q[S+2], n3 = q[S+3];
        case (trig_mode)
            2'b00: return (n2 == 0 && n1 == 1 && n0 == 0);
            2'b01: return filt_en ? (n3 == 0 && n2 == 0 && n1 == 1 && n0 == 1)
                                  : (n1 == 0 && n0 == 1);
            2'b10: return filt_en ? (n3 == 1 && n2 == 1 && n1 == 0 && n0 == 0)
                                  : (n1 == 1 && n0 == 0);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q = {};
            repeat (S + 4) q.push_back(0);
            m_pend = 0; m_st = 0; m_cnt = 0;
        end else begin
            int e, f;
            e = m_evt();
            f = (m_st == 0 && m_pend == 1 && ack == 1);
            m_pend = (e != 0 || (m_pend == 1 && f == 0)) ? 1 : 0;
            if (m_st == 0) begin
                if (f != 0) begin m_st = 1; m_cnt = 0; end
            end else if (m_st == 1) begin
                if (m_cnt == RL - 1) m_st = 2;
                else m_cnt++;
            end else m_st = 0;
            q.push_front(int'(start_raw));
            void'(q.pop_back());
        end
        cmp_on = 1;
    end

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (cmp_on && !finished) begin
            chk("start_pending", int'(start_pending), m_pend);
            chk("start_fire", int'(start_fire), (m_st == 0 && m_pend == 1 && ack == 1) ? 1 : 0);
            chk("ctl_busy", int'(ctl_busy), (m_st != 0) ? 1 : 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        ack = 1'b1; step(3 * (RL + 2)); ack = 1'b0; step(2);
    endtask

    task automatic pulse_raw(input int width);
        start_raw = 1'b1; step(width); start_raw = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(3);
        cur_req = "R1";
        chk("reset pending", int'(start_pending), 0);
        chk("reset busy", int'(ctl_busy), 0);
        chk("reset fire", int'(start_fire), 0);
        rst = 1'b0;
        step(2);

        // R2 / R4: unfiltered rising edge latency, then R7 hold
        cur_req = "R2"; trig_mode = 2'b01; filt_en = 1'b0;
        start_raw = 1'b1; step(S + 3);
        cur_req = "R7"; step(6);
        cur_req = "R8"; drain();

        cur_req = "R4"; trig_mode = 2'b10; start_raw = 1'b0; step(8); drain();
        cur_req = "R4"; trig_mode = 2'b01; pulse_raw(1); step(8); drain();

        // R5: filtered, glitches rejected
        cur_req = "R5"; filt_en = 1'b1; trig_mode = 2'b01;
        pulse_raw(1); step(10);
        start_raw = 1'b1; step(10); drain();
        trig_mode = 2'b10; pulse_raw(0); start_raw = 1'b0; step(1);
        start_raw = 1'b1; step(8);
        start_raw = 1'b0; step(10); drain();

        // R3: pulse mode, filter irrelevant, wide pulse ignored
        cur_req = "R3"; trig_mode = 2'b00;
        for (int fe = 0; fe < 2; fe++) begin
            filt_en = fe[0];
            pulse_raw(1); step(8); drain();
            pulse_raw(2); step(8); drain();
            pulse_raw(3); step(8);
        end

        // R6: disabled mode and steady levels
        cur_req = "R6"; trig_mode = 2'b11;
        pulse_raw(1); step(3); pulse_raw(4); step(6);
        trig_mode = 2'b01; filt_en = 1'b0; start_raw = 1'b1; step(10); drain();
        step(10); start_raw = 1'b0; trig_mode = 2'b10; step(10); drain(); step(10);

        // R11: pulses while busy are served afterwards
        cur_req = "R11"; trig_mode = 2'b00; filt_en = 1'b0;
        ack = 1'b1;
        pulse_raw(1); step(S + 3);
        pulse_raw(1); step(2); pulse_raw(1); step(3 * (RL + 2));
        ack = 1'b0; step(2);

        // R9: acknowledge sweep against a fresh detection
        cur_req = "R9";
        for (int d = 0; d < 7; d++) begin
            pulse_raw(1); step(S + 4);
            pulse_raw(1); step(d);
            ack = 1'b1; step(1); ack = 1'b0;
            step(RL + 4);
            drain();
        end

        // R8 / R10: random segments
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            start_raw = 1'($urandom_range(0, 3) == 0) ^ start_raw;
            ack = 1'($urandom_range(0, 1));
            if (i % 50 == 0) begin
                trig_mode = 2'($urandom_range(0, 3));
                filt_en = 1'($urandom_range(0, 1));
            end
        end
        ack = 1'b0;
        step(4);
        finish_run();
    end
endmodule